// File: doc/BRIEF.md
# Boost Regulator Mode Sequencer

This block is the control state machine of a battery-fed boost regulator. It chooses the operating mode: off, a two-stage linear precharge of the output, soft-start, regulated boost, automatic pass-through (bypass), bypass forced from a pin, and a fault hold-off followed by a retry. Its inputs are the enable and forced-bypass pins, an undervoltage-OK flag, and single-bit comparator results from the analog side. It drives switch enables, a precharge current level, a half-current-limit flag for soft-start, the state code, and a one-cycle fault strobe.

Every duration is counted in strobes of `tick_i`, which comes from a shared timebase. The clock is not used for timing. One shared timer counts strobes in the current state and restarts on every state change. Two persistence counters track how long the current limit has been held and how long switching has been quiet.

Top module: `boost_mode_seq`

## Requirements
- R1: After reset the state code is 0 (off), and every switch enable, `mod_en_o`, `half_ilim_o`, `pre_hi_o` and `fault_o` is low. The codes are off=0, precharge-low=1, precharge-high=2, soft-start=3, boost=4, auto-bypass=5, forced-bypass=6, fault=7.
- R2: From off, with enable, undervoltage-OK and the bypass pin all high, the next edge enters precharge-low (code 1). In this state `in_sw_lin_o`=1 and `pre_hi_o`=0. In either precharge state, `near_in_i` high moves to soft-start on the next edge.
- R3: Precharge-low that sees LIN1_TMO (512) ticks without exit moves to precharge-high (code 2), where `pre_hi_o`=1.
- R4: Precharge-high that sees LIN2_TMO (1024) ticks without exit moves to fault.
- R5: In soft-start `half_ilim_o`=1 and `mod_en_o`=1. After SS_TMO (64) ticks without `at_tgt_i`, the block enters fault.
- R6: When `at_tgt_i` is seen in soft-start, the next state is auto-bypass if `in_above_tgt_i` is high, and boost otherwise.
- R7: In boost, `ilim_i` held for OCP_TMO (2) consecutive ticks causes fault on the following edge. A current limit that drops before then has no effect.
- R8: Boost moves to auto-bypass when `out_below_in_i` is high and `sw_act_i` has been low for QUIET_TMO (5) ticks. For the first SOFT_TMO (5) ticks of auto-bypass only `in_sw_lin_o` is on; after that `in_sw_on_o` is on. `out_sw_on_o` is on throughout. `in_above_tgt_i` low returns the block to boost.
- R9: In auto-bypass, `drop_hi_i` high causes fault on the next edge.
- R10: In fault, all switch enables and `mod_en_o` are low. `fault_o` is high only in the first fault cycle. After RETRY_TMO (20) ticks the block restarts in precharge-low. Clock cycles without a tick do not advance any timeout.
- R11: Enable low returns the block to off on the next edge from any state. Undervoltage-OK low does the same from any state except forced-bypass.
- R12: Enable high with the bypass pin low enters forced-bypass (code 6) from any state. The switches stay open until `out_below_in_i` has been seen, then stay closed. Undervoltage loss is ignored there. Releasing the bypass pin restarts precharge-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable |
| byp_n_i | input | 1 | Forced-bypass request, active low |
| uv_ok_i | input | 1 | Supply above undervoltage lockout |
| tick_i | input | 1 | Timebase strobe, one per time unit |
| near_in_i | input | 1 | Output within precharge margin of input |
| at_tgt_i | input | 1 | Output has reached regulation target |
| in_above_tgt_i | input | 1 | Input above regulation target |
| ilim_i | input | 1 | Boost current limit active |
| drop_hi_i | input | 1 | Input-to-output drop above bypass limit |
| sw_act_i | input | 1 | Switching occurred this cycle |
| out_below_in_i | input | 1 | Output below input |
| state_o | output | 3 | Current state code |
| pre_hi_o | output | 1 | Precharge current level: 0 low, 1 high |
| half_ilim_o | output | 1 | Boost current limit at half level |
| in_sw_lin_o | output | 1 | Input switch as linear current source |
| in_sw_on_o | output | 1 | Input switch fully on |
| out_sw_on_o | output | 1 | Output switch held fully on |
| mod_en_o | output | 1 | Boost modulator enable |
| fault_o | output | 1 | One-cycle strobe on fault entry |

## Verification
The bench samples each timed exit one cycle before and at the expected strobe count. This exposes an off-by-one timer, which would leave a state one tick early or late, and a timer that is not cleared on state change, which would cut a later window short. A slow tick pattern shows that a timer counting clocks instead of strobes retries twice as fast. Separate stimuli check that a broken current-limit run never faults and that the quiet window restarts when switching is seen. A design that ignored this would enter bypass at once. In forced-bypass the bench checks that the switches stay open until the output is below the input, and that undervoltage loss does not drop the state.

// File: rtl/bms_pkg.sv
package bms_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_PRE_L = 3'd1,
    ST_PRE_H = 3'd2,
    ST_SOFT  = 3'd3,
    ST_BOOST = 3'd4,
    ST_ABYP  = 3'd5,
    ST_FBYP  = 3'd6,
    ST_FAULT = 3'd7
  } bms_state_e;
endpackage

// File: rtl/bms_timer.sv
// Counts timebase strobes in the current state, restarts on every state change.
module bms_timer #(
  parameter int MAX_CNT = 1024,
  localparam int TW = $clog2(MAX_CNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  output logic [TW-1:0] cnt
);
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = restart || (tick && (cnt != TW'(MAX_CNT)));
    cnt_d  = restart ? '0 : cnt + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/bms_persist.sv
// Counts strobes while a condition holds; cleared whenever it drops.
module bms_persist #(
  parameter int LIMIT = 2,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  output logic done
);
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = !cond || (tick && (cnt != W'(LIMIT)));
    cnt_d  = cond ? cnt + W'(1) : '0;
    done   = (cnt == W'(LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/bms_next.sv
module bms_next
  import bms_pkg::*;
#(
  parameter int LIN1_TMO  = 512,
  parameter int LIN2_TMO  = 1024,
  parameter int SS_TMO    = 64,
  parameter int RETRY_TMO = 20,
  parameter int TW        = 11
) (
  input  bms_state_e    cur,
  input  logic [TW-1:0] cnt,
  input  logic          tick,
  input  logic          en,
  input  logic          byp_n,
  input  logic          uv_ok,
  input  logic          near_in,
  input  logic          at_tgt,
  input  logic          in_above_tgt,
  input  logic          drop_hi,
  input  logic          out_below_in,
  input  logic          ocp_done,
  input  logic          quiet_done,
  output bms_state_e    nxt
);
  logic lin1_exp, lin2_exp, ss_exp, retry_exp;

  always_comb begin
    lin1_exp  = tick && (cnt == TW'(LIN1_TMO - 1));
    lin2_exp  = tick && (cnt == TW'(LIN2_TMO - 1));
    ss_exp    = tick && (cnt == TW'(SS_TMO - 1));
    retry_exp = tick && (cnt == TW'(RETRY_TMO - 1));
  end

  always_comb begin
    nxt = cur;
    if (!en) begin
      nxt = ST_OFF;
    end else if (!byp_n) begin
      nxt = ST_FBYP;
    end else if (!uv_ok) begin
      nxt = ST_OFF;
    end else begin
      unique case (cur)
        ST_OFF:   nxt = ST_PRE_L;
        ST_PRE_L: if (near_in) nxt = ST_SOFT;
                  else if (lin1_exp) nxt = ST_PRE_H;
        ST_PRE_H: if (near_in) nxt = ST_SOFT;
                  else if (lin2_exp) nxt = ST_FAULT;
        ST_SOFT:  if (at_tgt) nxt = in_above_tgt ? ST_ABYP : ST_BOOST;
                  else if (ss_exp) nxt = ST_FAULT;
        ST_BOOST: if (ocp_done) nxt = ST_FAULT;
                  else if (out_below_in && quiet_done) nxt = ST_ABYP;
        ST_ABYP:  if (drop_hi) nxt = ST_FAULT;
                  else if (!in_above_tgt) nxt = ST_BOOST;
        ST_FBYP:  nxt = ST_PRE_L;
        ST_FAULT: if (retry_exp) nxt = ST_PRE_L;
        default:  nxt = ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/bms_outdec.sv
module bms_outdec
  import bms_pkg::*;
#(
  parameter int SOFT_TMO = 5,
  parameter int TW       = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bms_state_e    cur,
  input  bms_state_e    nxt,
  input  logic [TW-1:0] cnt,
  input  logic          out_below_in,
  output logic          pre_hi,
  output logic          half_ilim,
  output logic          in_sw_lin,
  output logic          in_sw_on,
  output logic          out_sw_on,
  output logic          mod_en,
  output logic          fault_pls
);
  logic fb_closed, fb_closed_d;
  logic fault_d;
  logic soft_phase;

  always_comb begin
    fb_closed_d = (cur == ST_FBYP) && (fb_closed || out_below_in);
    fault_d     = (nxt == ST_FAULT) && (cur != ST_FAULT);
    soft_phase  = (cnt < TW'(SOFT_TMO));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_closed <= 1'b0;
      fault_pls <= 1'b0;
    end else begin
      fb_closed <= fb_closed_d;
      fault_pls <= fault_d;
    end
  end

  always_comb begin
    pre_hi    = 1'b0;
    half_ilim = 1'b0;
    in_sw_lin = 1'b0;
    in_sw_on  = 1'b0;
    out_sw_on = 1'b0;
    mod_en    = 1'b0;
    unique case (cur)
      ST_PRE_L: in_sw_lin = 1'b1;
      ST_PRE_H: begin in_sw_lin = 1'b1; pre_hi = 1'b1; end
      ST_SOFT:  begin mod_en = 1'b1; half_ilim = 1'b1; end
      ST_BOOST: mod_en = 1'b1;
      ST_ABYP:  begin
        out_sw_on = 1'b1;
        in_sw_lin = soft_phase;
        in_sw_on  = !soft_phase;
      end
      ST_FBYP:  begin in_sw_on = fb_closed; out_sw_on = fb_closed; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/boost_mode_seq.sv
module boost_mode_seq
  import bms_pkg::*;
#(
  parameter int LIN1_TMO  = 512,
  parameter int LIN2_TMO  = 1024,
  parameter int SS_TMO    = 64,
  parameter int OCP_TMO   = 2,
  parameter int QUIET_TMO = 5,
  parameter int SOFT_TMO  = 5,
  parameter int RETRY_TMO = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       byp_n_i,
  input  logic       uv_ok_i,
  input  logic       tick_i,
  input  logic       near_in_i,
  input  logic       at_tgt_i,
  input  logic       in_above_tgt_i,
  input  logic       ilim_i,
  input  logic       drop_hi_i,
  input  logic       sw_act_i,
  input  logic       out_below_in_i,
  output logic [2:0] state_o,
  output logic       pre_hi_o,
  output logic       half_ilim_o,
  output logic       in_sw_lin_o,
  output logic       in_sw_on_o,
  output logic       out_sw_on_o,
  output logic       mod_en_o,
  output logic       fault_o
);
  localparam int M1   = (LIN1_TMO > LIN2_TMO) ? LIN1_TMO : LIN2_TMO;
  localparam int M2   = (SS_TMO > RETRY_TMO) ? SS_TMO : RETRY_TMO;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M3 > SOFT_TMO) ? M3 : SOFT_TMO;
  localparam int TW   = $clog2(MAXT + 1);

  bms_state_e    cur, nxt;
  logic [TW-1:0] cnt;
  logic          ocp_done, quiet_done;
  logic          st_chg;

  always_comb st_chg = (nxt != cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= ST_OFF;
    else if (st_chg) cur <= nxt;
  end

  bms_timer #(.MAX_CNT(MAXT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .restart(st_chg), .cnt(cnt)
  );

  bms_persist #(.LIMIT(OCP_TMO)) u_ocp (
    .clk(clk), .rst_n(rst_n), .tick(tick_i),
    .cond(ilim_i && (cur == ST_BOOST)), .done(ocp_done)
  );

  bms_persist #(.LIMIT(QUIET_TMO)) u_quiet (
    .clk(clk), .rst_n(rst_n), .tick(tick_i),
    .cond(!sw_act_i), .done(quiet_done)
  );

  bms_next #(
    .LIN1_TMO(LIN1_TMO), .LIN2_TMO(LIN2_TMO), .SS_TMO(SS_TMO),
    .RETRY_TMO(RETRY_TMO), .TW(TW)
  ) u_next (
    .cur(cur), .cnt(cnt), .tick(tick_i), .en(en_i), .byp_n(byp_n_i),
    .uv_ok(uv_ok_i), .near_in(near_in_i), .at_tgt(at_tgt_i),
    .in_above_tgt(in_above_tgt_i), .drop_hi(drop_hi_i),
    .out_below_in(out_below_in_i), .ocp_done(ocp_done),
    .quiet_done(quiet_done), .nxt(nxt)
  );

  bms_outdec #(.SOFT_TMO(SOFT_TMO), .TW(TW)) u_out (
    .clk(clk), .rst_n(rst_n), .cur(cur), .nxt(nxt), .cnt(cnt),
    .out_below_in(out_below_in_i), .pre_hi(pre_hi_o),
    .half_ilim(half_ilim_o), .in_sw_lin(in_sw_lin_o),
    .in_sw_on(in_sw_on_o), .out_sw_on(out_sw_on_o),
    .mod_en(mod_en_o), .fault_pls(fault_o)
  );

  always_comb state_o = cur;
endmodule

// File: rtl/bms_chk.sv
module bms_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       byp_n_i,
  input logic       uv_ok_i,
  input logic [2:0] state_o,
  input logic       half_ilim_o,
  input logic       in_sw_lin_o,
  input logic       in_sw_on_o,
  input logic       out_sw_on_o,
  input logic       mod_en_o,
  input logic       fault_o
);
  a_r11_en_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (state_o == 3'd0));

  a_r12_uv_ignored_fbyp: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6 && en_i && !byp_n_i && !uv_ok_i) |=> (state_o == 3'd6));

  a_r10_pulse_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (state_o == 3'd7));

  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o);

  a_r10_fault_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd7) |-> !(in_sw_lin_o || in_sw_on_o || out_sw_on_o || mod_en_o));

  a_r8_in_sw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_sw_lin_o && in_sw_on_o));

  a_r5_half_only_soft: assert property (@(posedge clk) disable iff (!rst_n)
    half_ilim_o |-> (state_o == 3'd3));

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |-> !(in_sw_lin_o || in_sw_on_o || out_sw_on_o || mod_en_o));
endmodule

bind boost_mode_seq bms_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .byp_n_i(byp_n_i), .uv_ok_i(uv_ok_i),
  .state_o(state_o), .half_ilim_o(half_ilim_o), .in_sw_lin_o(in_sw_lin_o),
  .in_sw_on_o(in_sw_on_o), .out_sw_on_o(out_sw_on_o), .mod_en_o(mod_en_o),
  .fault_o(fault_o)
);

// File: tb/boost_mode_seq_tb.sv
module boost_mode_seq_tb;
  localparam int T_L1 = 512, T_L2 = 1024, T_SS = 64, T_OCP = 2;
  localparam int T_Q = 5, T_SOFT = 5, T_RTY = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic en, byp_n, uv_ok, tick, near_in, at_tgt, in_above, ilim, drop_hi, sw_act, obi;
  logic [2:0] st;
  logic pre_hi, half_ilim, sw_lin, sw_on, osw_on, mod_en, flt;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  boost_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .byp_n_i(byp_n), .uv_ok_i(uv_ok),
    .tick_i(tick), .near_in_i(near_in), .at_tgt_i(at_tgt),
    .in_above_tgt_i(in_above), .ilim_i(ilim), .drop_hi_i(drop_hi),
    .sw_act_i(sw_act), .out_below_in_i(obi), .state_o(st),
    .pre_hi_o(pre_hi), .half_ilim_o(half_ilim), .in_sw_lin_o(sw_lin),
    .in_sw_on_o(sw_on), .out_sw_on_o(osw_on), .mod_en_o(mod_en), .fault_o(flt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // restart from off through precharge into soft-start
  task automatic to_soft();
    en = 0; step(1);
    en = 1; near_in = 1; step(1);
    chk("R2 precharge-low entry", st, 1);
    step(1);
    chk("R2 near-input exit to soft-start", st, 3);
    near_in = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      summary();
    end
  end

  initial begin
    rst_n = 0; en = 0; byp_n = 1; uv_ok = 1; tick = 1; near_in = 0; at_tgt = 0;
    in_above = 0; ilim = 0; drop_hi = 0; sw_act = 0; obi = 0;
    step(3);
    chk("R1 reset state", st, 0);
    chk("R1 reset switches", {sw_lin, sw_on, osw_on, mod_en, half_ilim, pre_hi, flt}, 0);
    rst_n = 1; step(2);
    chk("R1 off while disabled", st, 0);

    // R2, R3, R4: precharge timeouts
    en = 1; step(1);
    chk("R2 precharge-low entry", st, 1);
    chk("R2 low level", pre_hi, 0);
    chk("R2 linear input switch", sw_lin, 1);
    step(T_L1 - 1);
    chk("R3 still precharge-low one tick early", st, 1);
    step(1);
    chk("R3 precharge-high after timeout", st, 2);
    chk("R3 high level", pre_hi, 1);
    step(T_L2 - 1);
    chk("R4 still precharge-high one tick early", st, 2);
    step(1);
    chk("R4 fault after precharge-high timeout", st, 7);
    chk("R10 fault strobe on entry", flt, 1);
    chk("R10 switches off in fault", {sw_lin, sw_on, osw_on, mod_en}, 0);
    step(1);
    chk("R10 fault strobe single cycle", flt, 0);
    step(T_RTY - 2);
    chk("R10 still fault one tick early", st, 7);
    step(1);
    chk("R10 retry into precharge-low", st, 1);

    // R5 soft-start timeout
    to_soft();
    chk("R5 half limit", half_ilim, 1);
    chk("R5 modulator on", mod_en, 1);
    step(T_SS - 1);
    chk("R5 still soft-start one tick early", st, 3);
    step(1);
    chk("R5 fault after soft-start timeout", st, 7);

    // R6 completion routing
    to_soft();
    at_tgt = 1; in_above = 0; step(1);
    chk("R6 soft-start to boost", st, 4);
    to_soft();
    at_tgt = 1; in_above = 1; step(1);
    chk("R6 soft-start to auto-bypass", st, 5);

    // R7 current-limit persistence
    in_above = 0;
    to_soft();
    at_tgt = 1; step(1);
    chk("R7 boost entry", st, 4);
    ilim = 1; step(T_OCP);
    chk("R7 still boost before limit persists", st, 4);
    step(1);
    chk("R7 fault after held current limit", st, 7);
    ilim = 0;
    to_soft();
    step(1);
    for (int i = 0; i < 10; i++) begin
      ilim = 1; step(1); ilim = 0; step(1);
    end
    chk("R7 broken current limit ignored", st, 4);

    // R8 quiet window, soft phase, exit
    sw_act = 1; step(1);
    sw_act = 0; obi = 1; in_above = 1; step(T_Q);
    chk("R8 still boost inside quiet window", st, 4);
    step(1);
    chk("R8 auto-bypass after quiet window", st, 5);
    chk("R8 soft phase linear", sw_lin, 1);
    chk("R8 soft phase not full", sw_on, 0);
    chk("R8 output switch on", osw_on, 1);
    step(T_SOFT - 1);
    chk("R8 linear at last soft tick", sw_lin, 1);
    step(1);
    chk("R8 fully on after soft phase", sw_on, 1);
    in_above = 0; obi = 0; step(1);
    chk("R8 back to boost at target", st, 4);

    // R9 bypass drop fault
    to_soft();
    in_above = 1; step(1);
    chk("R9 in auto-bypass", st, 5);
    drop_hi = 1; step(1);
    chk("R9 fault on excessive drop", st, 7);
    drop_hi = 0; at_tgt = 0; in_above = 0;

    // R10 sparse ticks: retry counts strobes, not clocks
    to_soft();
    step(T_SS);
    chk("R5 fault again", st, 7);
    for (int i = 0; i < 2 * T_RTY - 1; i++) begin
      tick = (i % 2 == 1); step(1);
    end
    chk("R10 slow ticks still fault", st, 7);
    tick = 1; step(1);
    chk("R10 retry after 20 strobes", st, 1);

    // R11 enable and undervoltage
    uv_ok = 0; step(1);
    chk("R11 undervoltage to off", st, 0);
    uv_ok = 1; step(1);
    chk("R11 restart precharge", st, 1);
    en = 0; step(1);
    chk("R11 enable low to off", st, 0);

    // R12 forced bypass
    en = 1; byp_n = 0; obi = 0; step(1);
    chk("R12 forced-bypass entry", st, 6);
    step(3);
    chk("R12 switches open while output high", {sw_on, osw_on, sw_lin}, 0);
    obi = 1; step(1);
    chk("R12 switches closed after output below input", {sw_on, osw_on}, 3);
    obi = 0; step(1);
    chk("R12 switches stay closed", {sw_on, osw_on}, 3);
    uv_ok = 0; step(2);
    chk("R12 undervoltage ignored", st, 6);
    uv_ok = 1; byp_n = 1; step(1);
    chk("R12 release restarts precharge", st, 1);
    at_tgt = 1; to_soft(); step(1);
    byp_n = 0; step(1);
    chk("R12 forced-bypass from boost", st, 6);
    en = 0; step(1);
    chk("R11 off from forced-bypass", st, 0);

    summary();
  end
endmodule